// File: doc/BRIEF.md
# Framed Sample Streamer for a Streaming FFT

The block feeds a streaming FFT from a single-port sample memory. It reads one real-valued 16-bit word per sample and presents it as a complex sample with the imaginary half held at zero. Samples go out in natural address order as frames of a fixed length, 1024 by default. Start-of-packet and end-of-packet strobes mark each frame. A transfer happens only when the downstream side is ready, so the FFT sink can stall the stream at any point.

A `run` input requests streaming. While `run` is low the block rests idle. When `run` goes high, the block waits in a preparation state until the sink shows ready. It then issues a read of address 0 so that the first word is already present when valid rises. The memory has one cycle of read latency and a read-enabled output register that holds its value between reads. The block drives the memory's real output straight to the stream, so stalls keep the data steady without a second register. When `run` is still high at the acceptance of the last sample, the next frame follows with no gap. When `run` is low at that point, the stream stops and the block returns to idle. Lowering `run` partway through a frame does not cut that frame short.

Top module: `fft_frame_feeder`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `src_valid`, `src_sop`, `src_eop` and `mem_rd` are 0 and `mem_addr` is 0.
- R2: Each frame carries FRAME_LEN (default 1024) samples taken from memory addresses 0, 1, …, FRAME_LEN-1 in that order. The real part of the sample with index i equals the memory word at address i.
- R3: With `run` high and `snk_ready` low, the block issues no read and keeps `src_valid` low. In the first cycle that `snk_ready` is high, it issues a read of address 0 (`mem_rd`=1, `mem_addr`=0), and `src_valid` rises one cycle later with `src_sop`=1.
- R4: `src_imag` is 0 in every valid cycle.
- R5: `src_sop` is 1 only on the sample with index 0 and `src_eop` only on the sample with index FRAME_LEN-1. Neither is ever 1 while `src_valid` is 0.
- R6: A sample is transferred only in a cycle where `src_valid` and `snk_ready` are both 1. While `src_valid`=1 and `snk_ready`=0, the real part, `src_sop`, `src_eop` and `mem_addr` keep their values into the next cycle, and `src_valid` stays 1.
- R7: A memory read is issued only on the first fetch of a frame sequence or in a transfer cycle, never in a stall cycle. A transfer of sample i reads address (i+1) mod FRAME_LEN, unless it ends the stream.
- R8: When the last sample is transferred with `run` high, `src_valid` stays 1 in the next cycle and `src_sop`=1, with the sample from address 0.
- R9: When the last sample is transferred with `run` low, `src_valid` is 0 from the next cycle on and no read is issued. Lowering `run` before the last sample does not shorten the frame.
- R10: A reset asserted in the middle of a frame returns the block to idle (valid low, address 0). A later run starts a fresh frame at index 0 with `src_sop`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Request streaming; sampled at each end of frame to decide on the next |
| snk_ready | input | 1 | Sink ready from the FFT |
| mem_rdata | input | SAMPLE_W (16) | Sample memory read data, one cycle after `mem_rd`, held between reads |
| mem_rd | output | 1 | Sample memory read enable |
| mem_addr | output | ADDR_W (10) | Sample memory read address |
| src_valid | output | 1 | Stream sample valid |
| src_real | output | SAMPLE_W (16) | Real part of the sample |
| src_imag | output | SAMPLE_W (16) | Imaginary part, always 0 |
| src_sop | output | 1 | First sample of a frame |
| src_eop | output | 1 | Last sample of a frame |

## Verification
The stream is driven under five ready patterns: always ready, alternating, pseudo-random, long stalls with short ready bursts, and held low during preparation. The first pattern shows full-rate back-to-back frames. The alternating and random patterns expose any read or address step taken in a stall cycle. The long-stall pattern checks that data and strobes hold over many cycles. Holding ready low in preparation separates waiting for ready from prefetching early. Each run lowers `run` a few samples before the final end of frame, which shows that frames are not truncated and that the stream stops cleanly. A reset in the middle of a frame followed by a fresh run checks the restart at index 0.

// File: rtl/feeder_pkg.sv
package feeder_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_PREP   = 2'd1,
    ST_STREAM = 2'd2
  } feed_state_t;

  // Index that follows idx in a frame of len samples (natural order, wraps).
  function automatic int unsigned wrap_next(input int unsigned idx, input int unsigned len);
    return (idx + 1 >= len) ? 0 : idx + 1;
  endfunction

endpackage

// File: rtl/feeder_seq.sv
module feeder_seq
  import feeder_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        run,
  input  logic        snk_ready,
  input  logic        at_last,
  output logic        streaming,
  output logic        prefetch,
  output logic        xfer,
  output logic        load
);

  feed_state_t state, state_nx;

  assign streaming = (state == ST_STREAM);
  assign prefetch  = (state == ST_PREP) && run && snk_ready;
  assign xfer      = streaming && snk_ready;
  assign load      = prefetch || (xfer && (!at_last || run));

  always_comb begin
    state_nx = state;
    case (state)
      ST_IDLE:   if (run) state_nx = ST_PREP;
      ST_PREP:   if (!run) state_nx = ST_IDLE;
                 else if (snk_ready) state_nx = ST_STREAM;
      ST_STREAM: if (xfer && at_last && !run) state_nx = ST_IDLE;
      default:   state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_nx;
  end

  AST_PREP_WAITS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_PREP && !snk_ready) |=> !streaming); // R3
  AST_LOAD_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> snk_ready); // R7
  AST_STOP_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && at_last && !run) |=> (state == ST_IDLE)); // R9

endmodule

// File: rtl/feeder_beat_ctr.sv
module feeder_beat_ctr
  import feeder_pkg::*;
#(
  parameter int FRAME_LEN = 1024,
  parameter int ADDR_W    = $clog2(FRAME_LEN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              step,
  input  logic              streaming,
  output logic [ADDR_W-1:0] beat,
  output logic [ADDR_W-1:0] fetch_addr,
  output logic              at_first,
  output logic              at_last
);

  localparam int unsigned LAST = FRAME_LEN - 1;

  logic [ADDR_W-1:0] beat_succ;

  assign beat_succ  = ADDR_W'(wrap_next(int'(beat), FRAME_LEN));
  assign fetch_addr = streaming ? beat_succ : '0;
  assign at_first   = (beat == '0);
  assign at_last    = (beat == ADDR_W'(LAST));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     beat <= '0;
    else if (clear) beat <= '0;
    else if (step)  beat <= beat_succ;
  end

  AST_BEAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !step) |=> $stable(beat)); // R6
  AST_LAST_WRAPS: assert property (@(posedge clk) disable iff (!rst_n)
    (step && at_last) |=> at_first); // R8

endmodule

// File: rtl/feeder_marks.sv
module feeder_marks #(
  parameter int SAMPLE_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                streaming,
  input  logic                at_first,
  input  logic                at_last,
  input  logic [SAMPLE_W-1:0] mem_rdata,
  output logic                valid,
  output logic                sop,
  output logic                eop,
  output logic [SAMPLE_W-1:0] re,
  output logic [SAMPLE_W-1:0] im
);

  assign valid = streaming;
  assign sop   = streaming && at_first;
  assign eop   = streaming && at_last;
  assign re    = mem_rdata;
  assign im    = '0;

  AST_MARKS_NEED_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (sop || eop) |-> valid); // R5

endmodule

// File: rtl/fft_frame_feeder.sv
module fft_frame_feeder #(
  parameter int FRAME_LEN = 1024,
  parameter int SAMPLE_W  = 16,
  parameter int ADDR_W    = $clog2(FRAME_LEN)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run,
  input  logic                snk_ready,
  input  logic [SAMPLE_W-1:0] mem_rdata,
  output logic                mem_rd,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic                src_valid,
  output logic [SAMPLE_W-1:0] src_real,
  output logic [SAMPLE_W-1:0] src_imag,
  output logic                src_sop,
  output logic                src_eop
);

  logic              streaming, prefetch, xfer, load;
  logic              at_first, at_last;
  logic [ADDR_W-1:0] beat, fetch_addr;

  feeder_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .snk_ready (snk_ready),
    .at_last   (at_last),
    .streaming (streaming),
    .prefetch  (prefetch),
    .xfer      (xfer),
    .load      (load)
  );

  feeder_beat_ctr #(.FRAME_LEN(FRAME_LEN), .ADDR_W(ADDR_W)) u_ctr (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (prefetch),
    .step       (xfer),
    .streaming  (streaming),
    .beat       (beat),
    .fetch_addr (fetch_addr),
    .at_first   (at_first),
    .at_last    (at_last)
  );

  feeder_marks #(.SAMPLE_W(SAMPLE_W)) u_marks (
    .clk       (clk),
    .rst_n     (rst_n),
    .streaming (streaming),
    .at_first  (at_first),
    .at_last   (at_last),
    .mem_rdata (mem_rdata),
    .valid     (src_valid),
    .sop       (src_sop),
    .eop       (src_eop),
    .re        (src_real),
    .im        (src_imag)
  );

  assign mem_rd   = load;
  assign mem_addr = fetch_addr;

  AST_STALL_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (src_valid && !snk_ready) |-> !mem_rd); // R7
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (src_valid && !snk_ready) |=> (src_valid && $stable(src_sop) && $stable(src_eop)
                                   && $stable(mem_addr))); // R6
  AST_FIRST_FETCH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && !src_valid) |-> (mem_addr == '0)); // R3
  AST_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
    (src_valid && snk_ready && src_eop && run) |=> (src_valid && src_sop)); // R8
  AST_STOP_DROPS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (src_valid && snk_ready && src_eop && !run) |=> !src_valid); // R9

endmodule

// File: tb/test_fft_frame_feeder.sv
module test_fft_frame_feeder;

  localparam int LEN = 1024;
  localparam int SW  = 16;
  localparam int AW  = 10;

  logic          clk = 1'b0;
  logic          rst_n, run, snk_ready;
  logic [SW-1:0] mem_rdata;
  logic          mem_rd;
  logic [AW-1:0] mem_addr;
  logic          src_valid, src_sop, src_eop;
  logic [SW-1:0] src_real, src_imag;

  fft_frame_feeder #(.FRAME_LEN(LEN), .SAMPLE_W(SW)) i_fft_frame_feeder (
    .clk(clk), .rst_n(rst_n), .run(run), .snk_ready(snk_ready),
    .mem_rdata(mem_rdata), .mem_rd(mem_rd), .mem_addr(mem_addr),
    .src_valid(src_valid), .src_real(src_real), .src_imag(src_imag),
    .src_sop(src_sop), .src_eop(src_eop)
  );

  always #10 clk = ~clk;

  typedef struct {
    int            idx;
    logic [SW-1:0] data;
    bit            sop;
    bit            eop;
  } item_t;

  item_t       exp_q[$];
  int          n_checks = 0, n_fail = 0;
  int          rdy_mode = 4;
  int          cyc = 0;
  logic [15:0] seed = 16'h1234;
  logic [15:0] lfsr = 16'hACE1;
  bit          done = 0;
  bit          want_sop_next, want_idle_next, stall_prev;
  logic [SW-1:0] sv_real;
  logic          sv_sop, sv_eop;
  logic [AW-1:0] sv_addr;

  function automatic logic [SW-1:0] mem_f(input int a);
    return SW'(a * 40503) ^ seed;
  endfunction

  // Sample memory: one-cycle latency, output held when not read.
  always @(posedge clk) if (mem_rd) mem_rdata <= mem_f(int'(mem_addr));

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // Driver: expected items for n frames.
  task automatic push_frames(input int n);
    for (int f = 0; f < n; f++)
      for (int i = 0; i < LEN; i++) begin
        item_t it;
        it.idx = i; it.data = mem_f(i); it.sop = (i == 0); it.eop = (i == LEN - 1);
        exp_q.push_back(it);
      end
  endtask

  // Ready generator and monitor.
  always @(negedge clk) begin
    cyc++;
    case (rdy_mode)
      0: snk_ready = 1'b1;
      1: snk_ready = cyc[0];
      2: begin lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
               snk_ready = lfsr[0] | lfsr[5]; end
      3: snk_ready = ((cyc % 16) < 3);
      default: snk_ready = 1'b0;
    endcase
    #1;
    if (rst_n) begin
      if (want_sop_next) check(src_valid && src_sop, "R8 back-to-back sop", {src_valid, src_sop}, 2'b11);
      if (want_idle_next) check(!src_valid, "R9 valid after stop", src_valid, 0);
      if (stall_prev)
        check(src_valid && src_real == sv_real && src_sop == sv_sop && src_eop == sv_eop
              && mem_addr == sv_addr, "R6 hold during stall", src_real, sv_real);
      want_sop_next = 0; want_idle_next = 0; stall_prev = 0;
      if (src_valid) check(src_imag == 0, "R4 imag zero", src_imag, 0);
      else check(!src_sop && !src_eop, "R5 marks without valid", {src_sop, src_eop}, 0);
      if (src_valid && !snk_ready) begin
        check(!mem_rd, "R7 no read in stall", mem_rd, 0);
        sv_real = src_real; sv_sop = src_sop; sv_eop = src_eop; sv_addr = mem_addr;
        stall_prev = 1;
      end
      if (src_valid && snk_ready) begin
        if (exp_q.size() == 0) check(0, "R2 unexpected transfer", src_real, 0);
        else begin
          item_t it;
          it = exp_q.pop_front();
          check(src_real == it.data, "R2 sample data", src_real, it.data);
          check(src_sop == it.sop && src_eop == it.eop, "R5 sop/eop position",
                {src_sop, src_eop}, {it.sop, it.eop});
          if (!it.eop || run)
            check(mem_rd && mem_addr == AW'((it.idx + 1) % LEN), "R7 next read address",
                  {mem_rd, mem_addr}, {1'b1, AW'((it.idx + 1) % LEN)});
          else check(!mem_rd, "R9 no read at stop", mem_rd, 0);
        end
        if (src_eop) begin
          if (run) want_sop_next = 1; else want_idle_next = 1;
        end
      end
    end
  end

  task automatic run_frames(input int n, input int mode, input logic [15:0] s);
    seed = s; rdy_mode = mode;
    push_frames(n);
    @(negedge clk); run = 1;
    while (exp_q.size() >= 8) @(negedge clk);
    run = 0;  // R9: lowered before the final end of frame
    while (exp_q.size() > 0) @(negedge clk);
    repeat (6) @(negedge clk);
    #2;
    check(!src_valid && !mem_rd, "R9 idle after stop", {src_valid, mem_rd}, 0);
    check(exp_q.size() == 0, "R9 frame complete", exp_q.size(), 0);
  endtask

  initial begin
    rst_n = 0; run = 0; snk_ready = 0;
    repeat (4) @(negedge clk);
    #2;
    check(!src_valid && !src_sop && !src_eop && !mem_rd && mem_addr == 0, "R1 in reset",
          {src_valid, src_sop, src_eop, mem_rd, 22'(mem_addr)}, 0);
    @(negedge clk); rst_n = 1;
    @(negedge clk); #2;
    check(!src_valid && !mem_rd && mem_addr == 0, "R1 after reset",
          {src_valid, mem_rd, 22'(mem_addr)}, 0);

    // R3: preparation waits for ready, then prefetches address 0.
    rdy_mode = 4; seed = 16'h0F0F;
    push_frames(1);
    run = 1;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk); #2;
      check(!src_valid && !mem_rd, "R3 wait for ready", {src_valid, mem_rd}, 0);
    end
    rdy_mode = 0;
    @(negedge clk); #2;
    check(mem_rd && mem_addr == 0 && !src_valid, "R3 prefetch address 0",
          {src_valid, mem_rd, 22'(mem_addr)}, 32'h40_0000);
    @(negedge clk); #2;
    check(src_valid && src_sop, "R3 valid one cycle later", {src_valid, src_sop}, 2'b11);
    while (exp_q.size() >= 8) @(negedge clk);
    run = 0;
    while (exp_q.size() > 0) @(negedge clk);
    repeat (4) @(negedge clk);

    run_frames(2, 0, 16'h5A5A);
    run_frames(3, 1, 16'hC3C3);
    run_frames(2, 2, 16'h7E81);
    run_frames(2, 3, 16'h1F2E);

    // R10: reset in the middle of a frame.
    seed = 16'h3344; rdy_mode = 2;
    push_frames(1);
    @(negedge clk); run = 1;
    while (exp_q.size() >= 600) @(negedge clk);
    rst_n = 0; run = 0;
    exp_q.delete();
    want_sop_next = 0; want_idle_next = 0; stall_prev = 0;
    @(negedge clk); #2;
    check(!src_valid && !mem_rd && mem_addr == 0, "R10 reset mid-frame",
          {src_valid, mem_rd, 22'(mem_addr)}, 0);
    @(negedge clk); rst_n = 1;
    run_frames(1, 0, 16'h9999);

    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule